// File: doc/BRIEF.md
# Transmit Frame Launcher and Checker

This block sends one Ethernet frame that software has already placed, complete, in a byte-wide transmit buffer. Software loads the buffer with the whole frame, leading preamble and start delimiter and trailing frame check bytes included. It then writes the total byte count to the count register. A nonzero count starts the job. The block checks the count against the allowed frame sizes and reads the first eight buffer bytes to confirm the preamble. If both checks pass, it streams only the part between the preamble and the check bytes onto a byte output, one byte per clock, marked with valid and last.

Every job ends with a single-cycle interrupt pulse, whether the frame was sent or refused. A two-bit error code records why the most recent frame was refused. The count register reads back zero after a successful send. After a refusal it keeps the value that was written, so software can see which count was rejected.

The buffer is read through a synchronous port: the address and enable go out in one cycle, and the byte comes back in the next.

Top module: `tx_frame_launcher`

## Requirements
- R1: A count write with a nonzero value while idle loads the count register and starts a job. A write of zero is ignored: the count and the error code keep their values and no interrupt follows.
- R2: A count below 64 is refused without reading or sending any byte, and the error code becomes 1 (too short).
- R3: A count above 1530 is refused without sending any byte, and the error code becomes 2 (too long).
- R4: Buffer bytes 0 to 6 must be 0x55 and byte 7 must be 0xD5. If any of them differs, the frame is refused without sending any byte, and the error code becomes 3 (bad preamble).
- R5: An accepted frame sends buffer bytes 8 through count-5 in address order, on consecutive cycles with tx_valid high, which is count-12 bytes in total.
- R6: tx_last is high together with tx_valid on the final sent byte only.
- R7: After a successful send the count register reads 0. After a refusal it keeps the written count.
- R8: Each job produces exactly one tx_irq pulse lasting one cycle. For a sent frame it comes in the cycle after the last byte.
- R9: The error code is 0 from the cycle after a job starts, and after a job it holds its value until the next job starts.
- R10: Count writes that arrive while a job is running are ignored: they change neither the count nor the stream, and they cause no extra interrupt.
- R11: After reset the count is 0, the error code is 0, and tx_valid, tx_last and tx_irq are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_wr_en | input | 1 | Write strobe for the count register |
| cnt_wr_data | input | CNT_W (12) | Frame byte count to write |
| cnt_value | output | CNT_W (12) | Current count register value |
| err_code | output | 2 | Reason for the last refusal (0 none, 1 short, 2 long, 3 preamble) |
| buf_rd_en | output | 1 | Buffer read enable |
| buf_rd_addr | output | ADDR_W (11) | Buffer read address |
| buf_rd_data | input | 8 | Buffer byte, valid one cycle after the read |
| tx_data | output | 8 | Outgoing frame byte |
| tx_valid | output | 1 | tx_data carries a frame byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_irq | output | 1 | One-cycle pulse at the end of each job |

## Verification
A wrong internal state shows at the ports within a few cycles. An address counter that is off by one sends a preamble or check byte, or drops a payload byte, and the scoreboard sees the wrong byte at that position. A wrong end address moves tx_last and the interrupt, so the cycle after the expected final byte already differs. A latched preamble mismatch that is not cleared, or an error code that is not cleared, refuses the next good frame or reports a stale code as soon as that job ends. A state machine that accepts writes while busy changes the count readback, or produces a second interrupt, within a handful of cycles.

// File: rtl/txl_pkg.sv
package txl_pkg;

  typedef enum logic [1:0] {
    ERR_NONE     = 2'd0,
    ERR_SHORT    = 2'd1,
    ERR_LONG     = 2'd2,
    ERR_PREAMBLE = 2'd3
  } txl_err_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LEN,
    S_PRE,
    S_SEND,
    S_FIN
  } txl_state_e;

  // Verdict on a byte count against the allowed size window.
  function automatic txl_err_e f_len_verdict(input int cnt, input int min_len,
                                             input int max_len);
    if (cnt < min_len) return ERR_SHORT;
    if (cnt > max_len) return ERR_LONG;
    return ERR_NONE;
  endfunction

  // Byte expected at position idx of the leading preamble.
  function automatic logic [7:0] f_pre_byte(input int idx, input int pre_len);
    return (idx == pre_len - 1) ? 8'hD5 : 8'h55;
  endfunction

  // Address of the final byte that is streamed out.
  function automatic int f_last_addr(input int cnt, input int fcs_len);
    return cnt - fcs_len - 1;
  endfunction

endpackage

// File: rtl/txl_len_check.sv
module txl_len_check #(
  parameter int CNT_W   = 12,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1530
) (
  input  logic [CNT_W-1:0] count,
  output txl_pkg::txl_err_e verdict
);
  always_comb begin
    verdict = txl_pkg::f_len_verdict(int'(count), MIN_LEN, MAX_LEN);
  end
endmodule

// File: rtl/txl_pre_check.sv
module txl_pre_check #(
  parameter int PRE_LEN = 8,
  localparam int IDX_W  = $clog2(PRE_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             vld,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       data,
  output logic             done,
  output logic             bad
);
  logic seen_bad_q;
  logic mism;

  assign mism = vld && (data != txl_pkg::f_pre_byte(int'(idx), PRE_LEN));
  assign done = vld && (int'(idx) == PRE_LEN - 1);
  assign bad  = seen_bad_q | mism;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seen_bad_q <= 1'b0;
    else if (clear)  seen_bad_q <= 1'b0;
    else if (mism)   seen_bad_q <= 1'b1;
  end
endmodule

// File: rtl/tx_frame_launcher.sv
module tx_frame_launcher #(
  parameter int BUF_BYTES = 2048,
  parameter int MIN_LEN   = 64,
  parameter int MAX_LEN   = 1530,
  localparam int ADDR_W   = $clog2(BUF_BYTES),
  localparam int CNT_W    = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_wr_en,
  input  logic [CNT_W-1:0]  cnt_wr_data,
  output logic [CNT_W-1:0]  cnt_value,
  output logic [1:0]        err_code,
  output logic              buf_rd_en,
  output logic [ADDR_W-1:0] buf_rd_addr,
  input  logic [7:0]        buf_rd_data,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  output logic              tx_last,
  output logic              tx_irq
);
  import txl_pkg::*;

  localparam int PRE_LEN = 8;
  localparam int FCS_LEN = 4;
  localparam int IDX_W   = $clog2(PRE_LEN);

  txl_state_e        state_q;
  logic [CNT_W-1:0]  count_q;
  txl_err_e          err_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic              pre_vld_q;
  logic [IDX_W-1:0]  pre_idx_q;
  logic              send_vld_q;
  logic              send_last_q;
  logic              irq_q;

  // Named internal events
  logic              start_evt;
  logic              issue_pre;
  logic              issue_send;
  logic              at_last_addr;
  logic              busy_noend;
  logic              pre_done;
  logic              pre_bad;
  txl_err_e          len_verdict;
  logic [ADDR_W-1:0] last_addr;

  assign start_evt    = cnt_wr_en && (state_q == S_IDLE) && (cnt_wr_data != '0);
  assign issue_pre    = (state_q == S_PRE) && (rd_addr_q < ADDR_W'(PRE_LEN));
  assign issue_send   = (state_q == S_SEND);
  assign last_addr    = ADDR_W'(f_last_addr(int'(count_q), FCS_LEN));
  assign at_last_addr = (rd_addr_q == last_addr);
  assign busy_noend   = (state_q == S_LEN) || (state_q == S_PRE) || (state_q == S_SEND);

  txl_len_check #(
    .CNT_W   (CNT_W),
    .MIN_LEN (MIN_LEN),
    .MAX_LEN (MAX_LEN)
  ) u_len (
    .count   (count_q),
    .verdict (len_verdict)
  );

  txl_pre_check #(
    .PRE_LEN (PRE_LEN)
  ) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start_evt),
    .vld   (pre_vld_q),
    .idx   (pre_idx_q),
    .data  (buf_rd_data),
    .done  (pre_done),
    .bad   (pre_bad)
  );

  // Control state machine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      count_q   <= '0;
      err_q     <= ERR_NONE;
      rd_addr_q <= '0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start_evt) begin
            count_q <= cnt_wr_data;
            err_q   <= ERR_NONE;
            state_q <= S_LEN;
          end
        end
        S_LEN: begin
          if (len_verdict != ERR_NONE) begin
            err_q   <= len_verdict;
            irq_q   <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            rd_addr_q <= '0;
            state_q   <= S_PRE;
          end
        end
        S_PRE: begin
          if (issue_pre) rd_addr_q <= rd_addr_q + 1'b1;
          if (pre_done) begin
            if (pre_bad) begin
              err_q   <= ERR_PREAMBLE;
              irq_q   <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              state_q <= S_SEND;
            end
          end
        end
        S_SEND: begin
          rd_addr_q <= rd_addr_q + 1'b1;
          if (at_last_addr) state_q <= S_FIN;
        end
        S_FIN: begin
          count_q <= '0;
          irq_q   <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // Read-return pipeline tags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_vld_q   <= 1'b0;
      pre_idx_q   <= '0;
      send_vld_q  <= 1'b0;
      send_last_q <= 1'b0;
    end else begin
      pre_vld_q   <= issue_pre;
      pre_idx_q   <= rd_addr_q[IDX_W-1:0];
      send_vld_q  <= issue_send;
      send_last_q <= issue_send && at_last_addr;
    end
  end

  assign buf_rd_en   = issue_pre | issue_send;
  assign buf_rd_addr = rd_addr_q;
  assign tx_valid    = send_vld_q;
  assign tx_last     = send_last_q;
  assign tx_data     = send_vld_q ? buf_rd_data : 8'h00;
  assign tx_irq      = irq_q;
  assign cnt_value   = count_q;
  assign err_code    = err_q;

endmodule

// File: rtl/txl_checker.sv
module txl_checker #(
  parameter int CNT_W   = 12,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1530
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_noend,
  input logic             cnt_wr_en,
  input logic [CNT_W-1:0] cnt_value,
  input logic [1:0]       err_code,
  input logic             tx_valid,
  input logic             tx_last,
  input logic             tx_irq
);
  assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq);

  assert_irq_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |=> tx_irq);

  assert_last_with_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  assert_cleared_after_send_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |=> (cnt_value == '0));

  assert_reject_keeps_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq && err_code != 2'd0) |-> (cnt_value != '0));

  assert_busy_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_noend && cnt_wr_en) |=> (cnt_value == $past(cnt_value)));

  assert_stream_no_error_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (err_code == 2'd0));

  assert_short_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq && err_code == 2'd1) |-> (int'(cnt_value) < MIN_LEN));

  assert_long_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq && err_code == 2'd2) |-> (int'(cnt_value) > MAX_LEN));
endmodule

bind tx_frame_launcher txl_checker #(
  .CNT_W   (CNT_W),
  .MIN_LEN (MIN_LEN),
  .MAX_LEN (MAX_LEN)
) u_txl_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy_noend (busy_noend),
  .cnt_wr_en  (cnt_wr_en),
  .cnt_value  (cnt_value),
  .err_code   (err_code),
  .tx_valid   (tx_valid),
  .tx_last    (tx_last),
  .tx_irq     (tx_irq)
);

// File: tb/test_tx_frame_launcher.sv
module test_tx_frame_launcher;
  localparam int CLK_PERIOD = 10;
  localparam int BUF_BYTES  = 2048;
  localparam int ADDR_W     = 11;
  localparam int CNT_W      = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cnt_wr_en = 1'b0;
  logic [CNT_W-1:0]  cnt_wr_data = '0;
  logic [CNT_W-1:0]  cnt_value;
  logic [1:0]        err_code;
  logic              buf_rd_en;
  logic [ADDR_W-1:0] buf_rd_addr;
  logic [7:0]        buf_rd_data;
  logic [7:0]        tx_data;
  logic              tx_valid;
  logic              tx_last;
  logic              tx_irq;

  logic [7:0] mem [0:BUF_BYTES-1];
  logic [8:0] exp_q [$];   // {last, byte}
  int checks = 0;
  int errors = 0;
  int irq_seen = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_frame_launcher i_tx_frame_launcher (
    .clk(clk), .rst_n(rst_n), .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
    .cnt_value(cnt_value), .err_code(err_code), .buf_rd_en(buf_rd_en),
    .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_last(tx_last), .tx_irq(tx_irq)
  );

  always_ff @(posedge clk) begin
    if (buf_rd_en) buf_rd_data <= mem[buf_rd_addr];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: pops scoreboard entries as bytes appear
  always @(negedge clk) begin
    if (rst_n && tx_irq) irq_seen++;
    if (rst_n && tx_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected byte", int'(tx_data), -1);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk(tx_data == e[7:0], "R5 byte", int'(tx_data), int'(e[7:0]));
        chk(tx_last == e[8], "R6 last flag", int'(tx_last), int'(e[8]));
      end
    end else if (rst_n && tx_last) begin
      chk(1'b0, "R6 last without valid", 1, 0);
    end
  end

  function automatic logic [7:0] pay(input int seed, input int i);
    return 8'((i * 7 + seed * 13 + (i >> 3)) & 8'hFF);
  endfunction

  task automatic fill(input int cnt, input int seed, input int bad_idx);
    for (int i = 0; i < BUF_BYTES; i++) mem[i] = pay(seed, i);
    for (int i = 0; i < 7; i++) mem[i] = 8'h55;
    mem[7] = 8'hD5;
    if (bad_idx >= 0) mem[bad_idx] = mem[bad_idx] ^ 8'h01;
    if (cnt < 0) mem[0] = 8'h55;
  endtask

  task automatic write_cnt(input int v);
    @(negedge clk);
    cnt_wr_en = 1'b1;
    cnt_wr_data = CNT_W'(v);
    @(negedge clk);
    cnt_wr_en = 1'b0;
  endtask

  // Driver: loads a frame, queues what should come out, launches and waits
  task automatic run_frame(input int cnt, input int seed, input int bad_idx,
                           input int exp_err, input int busy_write);
    int n;
    fill(cnt, seed, bad_idx);
    if (exp_err == 0)
      for (int a = 8; a <= cnt - 5; a++)
        exp_q.push_back({(a == cnt - 5), mem[a]});
    write_cnt(cnt);
    chk(err_code == 2'd0, "R9 error cleared at start", int'(err_code), 0);
    chk(cnt_value == CNT_W'(cnt), "R1 count loaded", int'(cnt_value), cnt);
    if (busy_write != 0) begin
      repeat (20) @(negedge clk);
      cnt_wr_en = 1'b1; cnt_wr_data = CNT_W'(busy_write);
      @(negedge clk);
      cnt_wr_en = 1'b0;
      chk(cnt_value == CNT_W'(cnt), "R10 busy write ignored", int'(cnt_value), cnt);
    end
    n = 0;
    while (!tx_irq && n < 4000) begin @(negedge clk); n++; end
    chk(tx_irq == 1'b1, "R8 interrupt seen", int'(tx_irq), 1);
    chk(int'(err_code) == exp_err, "R2 R3 R4 error code", int'(err_code), exp_err);
    chk(cnt_value == ((exp_err == 0) ? '0 : CNT_W'(cnt)), "R7 count after job",
        int'(cnt_value), (exp_err == 0) ? 0 : cnt);
    chk(exp_q.size() == 0, "R5 all bytes sent", exp_q.size(), 0);
    @(negedge clk);
    chk(tx_irq == 1'b0, "R8 pulse one cycle", int'(tx_irq), 0);
    exp_q.delete();
  endtask

  initial begin
    int base;
    for (int i = 0; i < BUF_BYTES; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(cnt_value == '0, "R11 reset count", int'(cnt_value), 0);
    chk(err_code == 2'd0, "R11 reset error", int'(err_code), 0);
    chk(!tx_valid && !tx_last && !tx_irq, "R11 reset outputs",
        int'({tx_valid, tx_last, tx_irq}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_frame(64, 1, -1, 0, 0);         // R5 R6 minimum accepted
    run_frame(100, 2, -1, 0, 0);
    run_frame(1530, 3, -1, 0, 0);       // R5 maximum accepted
    run_frame(63, 4, -1, 1, 0);         // R2
    // R1: zero write ignored after a refusal
    base = irq_seen;
    write_cnt(0);
    repeat (10) @(negedge clk);
    chk(cnt_value == 12'd63, "R1 zero write keeps count", int'(cnt_value), 63);
    chk(err_code == 2'd1, "R9 error held", int'(err_code), 1);
    chk(irq_seen == base, "R1 zero write no interrupt", irq_seen - base, 0);
    run_frame(1531, 5, -1, 2, 0);       // R3
    run_frame(4000, 6, -1, 2, 0);       // R3
    run_frame(200, 7, 0, 3, 0);         // R4 first byte
    run_frame(200, 8, 7, 3, 0);         // R4 delimiter
    run_frame(200, 9, 3, 3, 0);         // R4 middle byte
    run_frame(1, 10, -1, 1, 0);         // R2
    // R10: write during a send
    base = irq_seen;
    run_frame(300, 11, -1, 0, 100);
    repeat (30) @(negedge clk);
    chk(irq_seen == base + 1, "R10 single interrupt", irq_seen - base, 1);
    chk(cnt_value == '0, "R10 count stays cleared", int'(cnt_value), 0);
    run_frame(65, 12, -1, 0, 0);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule